// File: doc/BRIEF.md
# Configurable SPI Word Master

This block is a serial master that moves one word per start request. The word can be 8 to 16 bits long. A 16-bit configuration word selects the word length, the SCK idle level, the sampling phase and a divider that sets the SCK rate. The configuration word also carries an enable bit. When `start` is pulsed with a legal configuration, the block drives its single active-low select, toggles SCK and shifts the transmit word out on MOSI with the most significant bit first. At the same time it assembles the bits arriving on MISO.

The configuration is latched when a transfer is accepted, so the configuration input may change while a transfer runs. The received word is right-justified and appears together with a one-cycle `done` pulse. A start request with an illegal configuration does not begin a transfer; it sets a sticky error flag instead.

Top module: `spi_word_master`

## Requirements
- R1: After reset `cs_n` is 1, `busy`, `done`, `mosi`, `cfg_err` are 0 and `rx_word` is 0.
- R2: The word length N comes from `mode[13:10]`: code 0000 gives 16 bits, and codes 1000 to 1111 give 8 + `mode[12:10]` bits.
- R3: A start is refused, with `cfg_err` set and no select asserted, if `mode[15]` is 0, if `mode[7:0]` is 0 or 1, or if `mode[13:10]` is 0001 to 0111. An accepted start clears `cfg_err`.
- R4: Each SCK half period lasts `mode[7:0]` system clocks, and one transfer has exactly 2N SCK edges. `done` rises (2N+1)·`mode[7:0]` clocks after the clock edge that accepts `start`.
- R5: While idle, SCK rests at the level of `mode[9]`, and it returns to that level at the end of a transfer.
- R6: With `mode[8]`=0, the first bit is on MOSI when `cs_n` falls. Bits are sampled on leading SCK edges and changed on trailing edges.
- R7: With `mode[8]`=1, bits change on leading SCK edges and are sampled on trailing edges.
- R8: Only the low N bits of `tx_word` are sent, most significant first. `rx_word` holds the N received bits in its low bits, with zeros above them.
- R9: `done` lasts one clock. `busy` is high from the accepting edge until `done`, and `cs_n` is low exactly while `busy` is high.
- R10: A `start` pulse during a transfer is ignored: it does not change the timing or the data of that transfer.
- R11: During a transfer, MOSI changes only on a clock where SCK also toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 16 | Configuration: enable, size code, polarity, phase, divider |
| start | input | 1 | Request one transfer |
| tx_word | input | 16 | Word to send (low N bits used) |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low slave select |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-clock end-of-transfer pulse |
| rx_word | output | 16 | Received word, right-justified |
| cfg_err | output | 1 | Sticky flag for a refused start |

## Verification
The assertions check on every cycle the relations that must always hold:
- select and busy agree;
- `done` is a single pulse that ends a busy period;
- MOSI is quiet between SCK toggles;
- a start with a zero or one divider, or with the enable bit clear, is refused.

Word-length decoding, the exact latency, the edge count, the bit order in both phase settings and the idle polarity need a slave model and a cycle count. Only the bench scenarios show these, each run against a model of the remote device.

// File: rtl/spi_word_master.sv
module spi_word_master #(
  parameter int DW = 16,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   mode,
  input  logic          start,
  input  logic [DW-1:0] tx_word,
  input  logic          miso,
  output logic          sck,
  output logic          mosi,
  output logic          cs_n,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rx_word,
  output logic          cfg_err
);
  localparam int NW = $clog2(DW + 1);
  localparam int EW = NW + 1;

  logic [3:0]    szc;
  logic [NW-1:0] n_d, n_q;
  logic          size_ok, go_ok;
  logic [DW-1:0] tx_al, tsr, rsr;
  logic [BW-1:0] baud_q, hcnt;
  logic [EW-1:0] ecnt;
  logic          cpha_q;
  logic          tick, lead, last_edge;

  assign szc     = mode[13:10];
  assign size_ok = (szc == 4'd0) || szc[3];
  assign go_ok   = mode[15] && size_ok && (mode[BW-1:0] > BW'(1));
  assign n_d     = (szc == 4'd0) ? NW'(16) : NW'(8 + int'(szc[2:0]));
  assign tx_al   = tx_word << (DW - int'(n_d));

  assign tick      = (hcnt == baud_q - BW'(1));
  assign lead      = ~ecnt[0];
  assign last_edge = (ecnt == {n_q, 1'b0});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cs_n    <= 1'b1;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
      cfg_err <= 1'b0;
      rx_word <= '0;
      n_q     <= '0;
      baud_q  <= '0;
      cpha_q  <= 1'b0;
      hcnt    <= '0;
      ecnt    <= '0;
      tsr     <= '0;
      rsr     <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        sck <= mode[9];
        if (start) begin
          if (go_ok) begin
            busy    <= 1'b1;
            cs_n    <= 1'b0;
            cfg_err <= 1'b0;
            n_q     <= n_d;
            baud_q  <= mode[BW-1:0];
            cpha_q  <= mode[8];
            hcnt    <= '0;
            ecnt    <= '0;
            rsr     <= '0;
            if (!mode[8]) begin
              mosi <= tx_al[DW-1];
              tsr  <= tx_al << 1;
            end else begin
              mosi <= 1'b0;
              tsr  <= tx_al;
            end
          end else begin
            cfg_err <= 1'b1;
          end
        end
      end else if (tick) begin
        hcnt <= '0;
        if (last_edge) begin
          busy    <= 1'b0;
          cs_n    <= 1'b1;
          done    <= 1'b1;
          mosi    <= 1'b0;
          rx_word <= rsr;
        end else begin
          sck  <= ~sck;
          ecnt <= ecnt + EW'(1);
          if (lead ^ cpha_q) begin
            rsr <= {rsr[DW-2:0], miso};
          end else begin
            mosi <= tsr[DW-1];
            tsr  <= tsr << 1;
          end
        end
      end else begin
        hcnt <= hcnt + BW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_word_master_chk.sv
module spi_word_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] mode,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        cs_n,
  input logic        sck,
  input logic        mosi,
  input logic        cfg_err
);
  assert_sel_tracks_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n == !busy);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  assert_bad_start_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (mode[7:0] < 8'd2 || !mode[15])) |=> (!busy && cfg_err));

  assert_mosi_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && $stable(sck)) |-> $stable(mosi));
endmodule

bind spi_word_master spi_word_master_chk chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .start(start), .busy(busy),
  .done(done), .cs_n(cs_n), .sck(sck), .mosi(mosi), .cfg_err(cfg_err)
);

// File: tb/spi_word_master_test.sv
module spi_word_master_test;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, miso = 1'b0;
  logic [15:0] mode = 16'h8202, tx_word = '0;
  logic sck, mosi, cs_n, busy, done, cfg_err;
  logic [15:0] rx_word;

  int checks = 0, fails = 0;
  logic [15:0] sw, got;
  int sidx, sn, edges;
  logic scpol, scpha;

  spi_word_master uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .start(start), .tx_word(tx_word),
    .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n), .busy(busy),
    .done(done), .rx_word(rx_word), .cfg_err(cfg_err)
  );

  always #(PERIOD/2) clk = ~clk;

  // Remote device model
  always @(negedge cs_n) begin
    sidx = sn - 1;
    if (!scpha) begin
      miso <= sw[sidx];
      sidx = sidx - 1;
    end
  end

  always @(sck) begin
    if (!cs_n) begin
      bit ld;
      ld = (sck != scpol);
      edges = edges + 1;
      if (ld ^ scpha) got = {got[14:0], mosi};
      else if (sidx >= 0) begin
        miso <= sw[sidx];
        sidx = sidx - 1;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [15:0] m);
    return (m[13:10] == 4'd0) ? 16 : 8 + int'(m[12:10]);
  endfunction

  task automatic xfer(input logic [15:0] m, input logic [15:0] tx,
                      input logic [15:0] s, input bit poke);
    int n, cyc, ndone;
    logic [15:0] msk;
    n = nbits(m);
    msk = 16'((32'd1 << n) - 1);
    mode = m; tx_word = tx; sw = s; sn = n; scpol = m[9]; scpha = m[8];
    got = '0; edges = 0; ndone = 0;
    repeat (3) @(negedge clk);
    chk("R5 idle sck", sck, m[9]);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk("R9 select on accept", {cs_n, busy}, 2'b01);
    if (!m[8]) chk("R6 first bit at select", mosi, tx[n-1]);
    cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (poke && cyc == 4) start = 1'b1;
      if (poke && cyc == 5) start = 1'b0;
      if (done) break;
    end
    if (cyc >= 20000) chk("R4 watchdog", 1, 0);
    chk("R4 latency", cyc, (2*n + 1) * int'(m[7:0]));
    chk("R4 edge count", edges, 2*n);
    chk(m[8] ? "R7 R8 sent word" : "R6 R8 sent word", got & msk, tx & msk);
    chk("R8 received word", rx_word, s & msk);
    chk("R9 idle after done", {cs_n, busy}, 2'b10);
    chk("R5 sck rests", sck, m[9]);
    @(negedge clk);
    chk("R9 done one clock", done, 1'b0);
    if (poke) chk("R10 no second transfer", {cs_n, busy}, 2'b10);
  endtask

  task automatic reject(input logic [15:0] m);
    mode = m;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R3 refused start", {cs_n, busy}, 2'b10);
    end
    chk("R3 error flag", cfg_err, 1'b1);
  endtask

  localparam logic [47:0] VEC [5] = '{
    {16'h8002, 16'hA5C3, 16'h3C5A},
    {16'hA303, 16'h12F0, 16'hFF96},
    {16'hBD02, 16'hFFFF, 16'h2AAA},
    {16'hB205, 16'h0ABC, 16'h0F0F},
    {16'hA4FF, 16'h0155, 16'h01AA}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {cs_n, busy, done, mosi, cfg_err}, 5'b10000);
    chk("R1 reset rx", rx_word, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R5 idle high", sck, 1'b1);

    for (int i = 0; i < 5; i++) xfer(VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], 1'b0);

    chk("R2 size code 1000", nbits(16'hA000), 8);
    reject(16'h8000);
    reject(16'h8001);
    reject(16'h0002);
    reject(16'h8402);
    xfer(16'h8002, 16'h1234, 16'hBEEF, 1'b0);
    chk("R3 error cleared", cfg_err, 1'b0);
    xfer(16'hAC02, 16'h00C5, 16'h005A, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    checks++;
    fails++;
    $display("FAIL R4 global watchdog expired: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule